// File: doc/BRIEF.md
# Eight-Channel Serial DAC Update Sequencer

This block feeds an eight-channel serial DAC over a master-only SPI link. Leaving reset, it first sends two set-up commands: a software reset of the converter, then a command that switches on the converter's internal reference. After that it takes audio or control samples from an upstream producer over a valid/ready handshake. Each 32-bit input word carries two 16-bit samples. Every sample becomes a 32-bit command word that writes one channel and updates its output at once.

Channels are written in ascending order. The low half of an input word goes to an even channel and the high half to the odd channel after it. Four input words therefore refresh channels 0 to 7, and the sequence then starts again at channel 0. Each command word is shifted out MSB first in SPI mode 1. It is framed by an active-low chip select that stays high for a minimum gap between words. A parameter sets the serial clock divider.

Top module: `dac_spi_sequencer`

## Requirements
- R1: Every serial word is 32 bits, sent MSB first. Bits 31:28 are zero, bits 27:24 carry the command, bits 23:20 the channel address, bits 19:4 the 16-bit data and bits 3:0 the flag field.
- R2: After each reset the first word sent is 0x07000000 (software reset) and the second is 0x08000001 (reference on). The sample ready output stays low until both have been sent.
- R3: A sample word uses command 0x3 and flag field 0. The low half (bits 15:0) of an accepted input word is sent first, to an even channel. The high half (bits 31:16) is sent next, to the following channel.
- R4: Channel addresses advance 0,1,…,7 across four accepted input words and then wrap to 0. A reset restarts them at channel 0.
- R5: The serial clock idles low whenever chip select is high. MOSI changes only together with a rising serial clock edge. Each word has exactly 32 falling serial clock edges while chip select is low.
- R6: Chip select is low for the whole word. Between words it stays high for at least two serial clock periods, which is 4×CLK_DIV clock cycles.
- R7: Sample ready drops in the cycle after an input word is accepted and stays low until both of that word's transfers have finished. It then returns high.
- R8: While reset is active, chip select is high, the serial clock is low and sample ready is low. A transfer in progress is abandoned.
- R9: The serial clock high and low phases each last exactly CLK_DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_data_i | input | 32 | Two packed samples: bits 15:0 even channel, bits 31:16 odd channel |
| smp_valid_i | input | 1 | Sample word offered |
| smp_ready_o | output | 1 | Sequencer can accept a sample word |
| sclk_o | output | 1 | Serial clock, mode 1, idle low |
| mosi_o | output | 1 | Serial data to the DAC |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
The handshake that accepts the next sample word can land in the same cycles as the shifter's enforced chip-select gap after the previous word. To provoke this, the bench offers each new word as soon as ready rises. It then measures the high time of chip select across all words and checks that the channel and data of every captured word follow the order. Reset can also fall in the middle of a shifted word. The bench aborts a transfer after a few bits and checks that the set-up pair is sent again and that channel numbering restarts at 0.

// File: rtl/dacseq_pkg.sv
// Package: shared command encodings and field layout for the DAC sequencer.
// Assumes the converter takes 32-bit words with a 4-bit command, a 4-bit
// address, 16-bit data and a 4-bit flag field, upper nibble unused.
package dacseq_pkg;

    localparam int DAC_WORD_W = 32;
    localparam int DAC_DATA_W = 16;
    localparam int DAC_ADDR_W = 4;

    localparam logic [3:0] CMD_WRITE_UPDATE = 4'h3;
    localparam logic [3:0] CMD_SOFT_RESET   = 4'h7;
    localparam logic [3:0] CMD_REF_SETUP    = 4'h8;
    localparam logic [3:0] FLAG_REF_ENABLE  = 4'h1;

    // Fields of one converter command, before packing
    typedef struct packed {
        logic [3:0]            cmd;
        logic [DAC_ADDR_W-1:0] addr;
        logic [DAC_DATA_W-1:0] data;
        logic [3:0]            flags;
    } dac_cmd_t;

endpackage

// File: rtl/dacseq_word_builder.sv
// Module: dacseq_word_builder
// Packs command fields into the 32-bit serial word. Purely combinational.
// Assumes the unused top nibble must be sent as zero.
module dacseq_word_builder
    import dacseq_pkg::*;
(
    input  dac_cmd_t                fields_i,
    output logic [DAC_WORD_W-1:0]   word_o
);

    localparam int PAD_W = DAC_WORD_W - $bits(dac_cmd_t);

    // Place the fields under a zero pad at the top of the word
    always_comb begin
        word_o = {{PAD_W{1'b0}}, fields_i};
    end

endmodule

// File: rtl/dacseq_spi_shifter.sv
// Module: dacseq_spi_shifter
// Shifts one word out MSB first in SPI mode 1 (clock idle low, data launched
// on the rising edge, captured by the slave on the falling edge). It frames
// the word with an active-low select and holds select high for a minimum gap
// afterwards. Assumes go_i is only honoured while idle_o is high.
module dacseq_spi_shifter #(
    parameter int HALF_DIV = 2,   // system cycles per serial clock phase
    parameter int GAP_SCLK = 2,   // minimum select-high time in serial periods
    parameter int WORD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              idle_o,
    output logic              done_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              cs_n_o
);

    localparam int DIV_W      = $clog2(HALF_DIV + 1);
    localparam int GAP_HALVES = 2 * GAP_SCLK;
    localparam int GAP_W      = $clog2(GAP_HALVES + 1);
    localparam int BIT_W      = $clog2(WORD_W);
    localparam int GAP_CYC    = GAP_HALVES * HALF_DIV;
    localparam int HI_W       = $clog2(GAP_CYC + 1);
    localparam int FALL_W     = $clog2(WORD_W + 1);

    typedef enum logic [2:0] {SH_IDLE, SH_LEAD, SH_HIGH, SH_LOW, SH_GAP} sh_state_t;

    sh_state_t         state;
    logic [DIV_W-1:0]  div_cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [GAP_W-1:0]  gap_cnt;
    logic [WORD_W-1:0] shreg;
    logic              sclk_q;
    logic              mosi_q;
    logic              cs_n_q;
    logic              done_q;
    logic              tick;

    // Phase tick: one serial half period has elapsed
    always_comb begin
        tick = (div_cnt == DIV_W'(HALF_DIV - 1));
    end

    // Half-period divider, running only while a word or gap is in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (state == SH_IDLE || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Framing and shift sequence: lead, 32 high/low phases, then select gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            bit_idx <= '0;
            gap_cnt <= '0;
            shreg   <= '0;
            sclk_q  <= 1'b0;
            mosi_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                SH_IDLE: begin
                    if (go_i) begin
                        shreg   <= word_i;
                        cs_n_q  <= 1'b0;
                        bit_idx <= '0;
                        state   <= SH_LEAD;
                    end
                end
                SH_LEAD: begin
                    if (tick) begin
                        sclk_q <= 1'b1;
                        mosi_q <= shreg[WORD_W-1];
                        shreg  <= {shreg[WORD_W-2:0], 1'b0};
                        state  <= SH_HIGH;
                    end
                end
                SH_HIGH: begin
                    if (tick) begin
                        sclk_q <= 1'b0;
                        state  <= SH_LOW;
                    end
                end
                SH_LOW: begin
                    if (tick) begin
                        if (bit_idx == BIT_W'(WORD_W - 1)) begin
                            cs_n_q  <= 1'b1;
                            done_q  <= 1'b1;
                            gap_cnt <= '0;
                            state   <= SH_GAP;
                        end else begin
                            sclk_q  <= 1'b1;
                            mosi_q  <= shreg[WORD_W-1];
                            shreg   <= {shreg[WORD_W-2:0], 1'b0};
                            bit_idx <= bit_idx + 1'b1;
                            state   <= SH_HIGH;
                        end
                    end
                end
                SH_GAP: begin
                    if (tick) begin
                        if (gap_cnt == GAP_W'(GAP_HALVES - 1)) begin
                            state <= SH_IDLE;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

    // Drive the pins and status straight from registers
    always_comb begin
        idle_o = (state == SH_IDLE);
        done_o = done_q;
        sclk_o = sclk_q;
        mosi_o = mosi_q;
        cs_n_o = cs_n_q;
    end

    // ---- checking logic: counters observing the pins over time ----
    logic              sclk_prev;
    logic [HI_W-1:0]   hi_cnt;
    logic [FALL_W-1:0] fall_cnt;

    // Previous serial clock level, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_q;
    end

    // Select-high duration, saturating at the required gap
    always_ff @(posedge clk) begin
        if (!rst_n)                       hi_cnt <= HI_W'(GAP_CYC);
        else if (!cs_n_q)                 hi_cnt <= '0;
        else if (hi_cnt != HI_W'(GAP_CYC)) hi_cnt <= hi_cnt + 1'b1;
    end

    // Falling serial edges seen while select is low
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_q)             fall_cnt <= '0;
        else if (sclk_prev && !sclk_q)    fall_cnt <= fall_cnt + 1'b1;
    end

    p_sclk_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sclk_q);

    p_mosi_rising_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(sclk_q) |-> $stable(mosi_q));

    p_word_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> (fall_cnt == FALL_W'(WORD_W)));

    p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_q) |-> (hi_cnt == HI_W'(GAP_CYC)));

endmodule

// File: rtl/dacseq_ctrl.sv
// Module: dacseq_ctrl
// Command sequencer. After reset it issues the converter reset and
// reference-enable commands. It then accepts packed sample words and issues
// one write-and-update command per half word, with channel numbers in rising
// order and wrapping. Assumes NUM_CH is even and no larger than 16.
module dacseq_ctrl
    import dacseq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*DAC_DATA_W-1:0] smp_data_i,
    input  logic                    smp_valid_i,
    output logic                    smp_ready_o,
    input  logic                    sh_idle_i,
    input  logic                    sh_done_i,
    output logic                    sh_go_o,
    output dac_cmd_t                fields_o
);

    localparam int CH_W = $clog2(NUM_CH);

    typedef enum logic [2:0] {CT_RESET_DAC, CT_REF_ON, CT_WAIT, CT_LOW, CT_HIGH} ct_state_t;

    ct_state_t               state;
    logic                    issued;
    logic [CH_W-1:0]         chan;
    logic [CH_W-1:0]         chan_next;
    logic [2*DAC_DATA_W-1:0] hold;

    // Next channel number, wrapping after the last one
    always_comb begin
        chan_next = (chan == CH_W'(NUM_CH - 1)) ? '0 : chan + 1'b1;
    end

    // Start a transfer once per command while the shifter is free
    always_comb begin
        sh_go_o     = (state != CT_WAIT) && !issued && sh_idle_i;
        smp_ready_o = (state == CT_WAIT);
    end

    // Select the fields of the command for the current step
    always_comb begin
        fields_o = '0;
        case (state)
            CT_RESET_DAC: fields_o.cmd = CMD_SOFT_RESET;
            CT_REF_ON: begin
                fields_o.cmd   = CMD_REF_SETUP;
                fields_o.flags = FLAG_REF_ENABLE;
            end
            CT_LOW: begin
                fields_o.cmd  = CMD_WRITE_UPDATE;
                fields_o.addr = DAC_ADDR_W'(chan);
                fields_o.data = hold[DAC_DATA_W-1:0];
            end
            CT_HIGH: begin
                fields_o.cmd  = CMD_WRITE_UPDATE;
                fields_o.addr = DAC_ADDR_W'(chan);
                fields_o.data = hold[2*DAC_DATA_W-1:DAC_DATA_W];
            end
            default: fields_o = '0;
        endcase
    end

    // Step through set-up, then sample pairs, advancing on each finished word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CT_RESET_DAC;
            issued <= 1'b0;
            chan   <= '0;
            hold   <= '0;
        end else begin
            if (sh_go_o) issued <= 1'b1;
            case (state)
                CT_WAIT: begin
                    if (smp_valid_i) begin
                        hold  <= smp_data_i;
                        state <= CT_LOW;
                    end
                end
                CT_RESET_DAC: if (sh_done_i) begin
                    issued <= 1'b0;
                    state  <= CT_REF_ON;
                end
                CT_REF_ON: if (sh_done_i) begin
                    issued <= 1'b0;
                    state  <= CT_WAIT;
                end
                CT_LOW: if (sh_done_i) begin
                    issued <= 1'b0;
                    chan   <= chan_next;
                    state  <= CT_HIGH;
                end
                CT_HIGH: if (sh_done_i) begin
                    issued <= 1'b0;
                    chan   <= chan_next;
                    state  <= CT_WAIT;
                end
                default: state <= CT_RESET_DAC;
            endcase
        end
    end

    p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && smp_ready_o) |=> !smp_ready_o);

    p_high_half_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CT_HIGH) |-> chan[0]);

    p_low_half_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CT_LOW) |-> !chan[0]);

    p_ready_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_ready_o) |-> $past(sh_done_i));

endmodule

// File: rtl/dac_spi_sequencer.sv
// Module: dac_spi_sequencer (top)
// Connects the command sequencer, the word packer and the mode-1 shifter.
// Assumes a synchronous active-low reset and CLK_DIV >= 1 system cycles per
// serial clock phase.
module dac_spi_sequencer
    import dacseq_pkg::*;
#(
    parameter int CLK_DIV     = 2,
    parameter int CS_GAP_SCLK = 2,
    parameter int NUM_CH      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] smp_data_i,
    input  logic        smp_valid_i,
    output logic        smp_ready_o,
    output logic        sclk_o,
    output logic        mosi_o,
    output logic        cs_n_o
);

    dac_cmd_t               fields;
    logic [DAC_WORD_W-1:0]  word;
    logic                   sh_go;
    logic                   sh_idle;
    logic                   sh_done;

    dacseq_ctrl #(
        .NUM_CH (NUM_CH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_data_i  (smp_data_i),
        .smp_valid_i (smp_valid_i),
        .smp_ready_o (smp_ready_o),
        .sh_idle_i   (sh_idle),
        .sh_done_i   (sh_done),
        .sh_go_o     (sh_go),
        .fields_o    (fields)
    );

    dacseq_word_builder u_builder (
        .fields_i (fields),
        .word_o   (word)
    );

    dacseq_spi_shifter #(
        .HALF_DIV (CLK_DIV),
        .GAP_SCLK (CS_GAP_SCLK),
        .WORD_W   (DAC_WORD_W)
    ) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (sh_go),
        .word_i (word),
        .idle_o (sh_idle),
        .done_o (sh_done),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o),
        .cs_n_o (cs_n_o)
    );

    p_reset_pins_r8: assert property (@(posedge clk)
        $past(!rst_n) |-> (cs_n_o && !sclk_o && !smp_ready_o));

endmodule

// File: tb/test_dac_spi_sequencer.sv
// Bench for dac_spi_sequencer: a vector table walked in one loop, then
// directed checks for reset behaviour and timing limits.
module test_dac_spi_sequencer;

    localparam int CLK_DIV = 2;
    localparam int GAP_MIN = 4 * CLK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] smp_data = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic        sclk, mosi, cs_n;

    always #4 clk = ~clk;

    dac_spi_sequencer #(.CLK_DIV(CLK_DIV), .CS_GAP_SCLK(2), .NUM_CH(8)) i_dac_spi_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_data_i  (smp_data),
        .smp_valid_i (smp_valid),
        .smp_ready_o (smp_ready),
        .sclk_o      (sclk),
        .mosi_o      (mosi),
        .cs_n_o      (cs_n)
    );

    // Input word, then expected low-half word and high-half word
    localparam logic [95:0] TBL [8] = '{
        {32'hBEEF_1234, 32'h0301_2340, 32'h031B_EEF0},
        {32'h0000_FFFF, 32'h032F_FFF0, 32'h0330_0000},
        {32'hFFFF_0000, 32'h0340_0000, 32'h035F_FFF0},
        {32'h8001_7FFE, 32'h0367_FFE0, 32'h0378_0010},
        {32'hA5A5_5A5A, 32'h0305_A5A0, 32'h031A_5A50},
        {32'h1357_2468, 32'h0322_4680, 32'h0331_3570},
        {32'hFFFF_FFFF, 32'h034F_FFF0, 32'h035F_FFF0},
        {32'h0F0F_F0F0, 32'h036F_0F00, 32'h0370_F0F0}
    };

    int nchk = 0;
    int nfail = 0;

    // Monitor state, written only by the monitor process
    logic [31:0] cap [64];
    int          capbits [64];
    int          ncap = 0;
    int          mon_bits = 0;
    logic [31:0] mon_sr = '0;
    int          idle_err = 0;
    int          mosi_err = 0;
    int          hi_run = 0, hi_min = 1000, hi_max = 0;
    int          lo_run = 0, lo_min = 1000, lo_max = 0;
    int          cs_run = 0, gap_min = 1000;
    bit          gap_ok = 0;
    logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

    // Pin monitor sampled at the falling system clock edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mon_bits = 0; gap_ok = 0; hi_run = 0; lo_run = 0; cs_run = 0;
            p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
        end else begin
            if (cs_n && sclk) idle_err++;
            if (!cs_n && mosi !== p_mosi && !(sclk && !p_sclk)) mosi_err++;
            if (p_sclk && !sclk) begin
                mon_sr = {mon_sr[30:0], mosi};
                mon_bits++;
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
                hi_run = 0;
            end
            if (!p_sclk && sclk && !cs_n && mon_bits > 0) begin
                if (lo_run < lo_min) lo_min = lo_run;
                if (lo_run > lo_max) lo_max = lo_run;
            end
            if (sclk) hi_run++;
            if (!sclk && !cs_n) lo_run++; else lo_run = 0;
            if (p_cs && !cs_n) begin
                if (gap_ok && cs_run < gap_min) gap_min = cs_run;
                mon_bits = 0;
            end
            if (!p_cs && cs_n) begin
                if (ncap < 64) begin
                    cap[ncap] = mon_sr;
                    capbits[ncap] = mon_bits;
                end
                ncap++;
                gap_ok = 1;
                cs_run = 0;
            end
            if (cs_n) cs_run++;
            p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic send(input logic [31:0] w);
        bit r;
        int t = 0;
        smp_data  = w;
        smp_valid = 1'b1;
        forever begin
            r = smp_ready;
            step();
            t++;
            if (r || t > 5000) break;
        end
        smp_valid = 1'b0;
    endtask

    task automatic wait_caps(input int n, output bit saw_ready);
        int t = 0;
        saw_ready = 0;
        while (ncap < n && t < 5000) begin
            step();
            if (ncap < n && smp_ready) saw_ready = 1;
            t++;
        end
    endtask

    function automatic logic [31:0] sample_word(input int ch, input logic [15:0] d);
        return {4'h0, 4'h3, 4'(ch), d, 4'h0};
    endfunction

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog R7 actual=%h expected=%h", 32'h0, 32'h1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
        $finish;
    end

    initial begin
        bit saw;
        int base;

        // R8: pin state while reset is held
        repeat (5) step();
        check(cs_n === 1'b1, "R8 cs_n in reset", 32'(cs_n), 32'h1);
        check(sclk === 1'b0, "R8 sclk in reset", 32'(sclk), 32'h0);
        check(smp_ready === 1'b0, "R8 ready in reset", 32'(smp_ready), 32'h0);
        rst_n = 1'b1;

        // R2: set-up pair, ready low meanwhile
        step();
        check(smp_ready === 1'b0, "R2 ready low after reset", 32'(smp_ready), 32'h0);
        wait_caps(2, saw);
        check(!saw, "R2 ready during set-up", 32'(saw), 32'h0);
        check(cap[0] === 32'h0700_0000, "R2 soft reset word", cap[0], 32'h0700_0000);
        check(cap[1] === 32'h0800_0001, "R2 reference word", cap[1], 32'h0800_0001);

        // R1 R3 R4 R7: vector table
        for (int i = 0; i < 8; i++) begin
            base = ncap;
            send(TBL[i][95:64]);
            check(smp_ready === 1'b0, "R7 ready drops after accept", 32'(smp_ready), 32'h0);
            wait_caps(base + 2, saw);
            check(!saw, "R7 ready held low over both words", 32'(saw), 32'h0);
            check(cap[base] === TBL[i][63:32], "R3 low half / R4 even channel", cap[base], TBL[i][63:32]);
            check(cap[base+1] === TBL[i][31:0], "R3 high half / R4 odd channel", cap[base+1], TBL[i][31:0]);
            step();
            step();
            check(smp_ready === 1'b1, "R7 ready returns", 32'(smp_ready), 32'h1);
        end

        // R8 R2 R4: reset in the middle of a word
        send(32'h2222_1111);
        begin
            int t = 0;
            while (mon_bits < 10 && t < 2000) begin step(); t++; end
        end
        rst_n = 1'b0;
        step();
        check(cs_n === 1'b1, "R8 cs_n after mid-word reset", 32'(cs_n), 32'h1);
        check(sclk === 1'b0, "R8 sclk after mid-word reset", 32'(sclk), 32'h0);
        check(smp_ready === 1'b0, "R8 ready after mid-word reset", 32'(smp_ready), 32'h0);
        step();
        step();
        rst_n = 1'b1;
        base = ncap;
        send(32'h0001_FFFE);
        wait_caps(base + 4, saw);
        check(cap[base] === 32'h0700_0000, "R2 soft reset repeated", cap[base], 32'h0700_0000);
        check(cap[base+1] === 32'h0800_0001, "R2 reference repeated", cap[base+1], 32'h0800_0001);
        check(cap[base+2] === sample_word(0, 16'hFFFE), "R4 channel restart at 0", cap[base+2], sample_word(0, 16'hFFFE));
        check(cap[base+3] === sample_word(1, 16'h0001), "R4 channel 1 after restart", cap[base+3], sample_word(1, 16'h0001));
        repeat (20) step();

        // R1 R5: every word had 32 bits
        for (int k = 0; k < ncap && k < 64; k++) begin
            check(capbits[k] == 32, "R1 R5 bits per word", 32'(capbits[k]), 32'd32);
        end
        check(idle_err == 0, "R5 sclk low while cs_n high", 32'(idle_err), 32'h0);
        check(mosi_err == 0, "R5 mosi moves only at rising sclk", 32'(mosi_err), 32'h0);
        check(gap_min >= GAP_MIN && gap_min < 1000, "R6 cs_n high gap", 32'(gap_min), 32'(GAP_MIN));
        check(hi_min == CLK_DIV && hi_max == CLK_DIV, "R9 sclk high phase", 32'(hi_max), 32'(CLK_DIV));
        check(lo_min == CLK_DIV && lo_max == CLK_DIV, "R9 sclk low phase", 32'(lo_max), 32'(CLK_DIV));

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule